// File: doc/BRIEF.md
# Board Interrupt Expander Controller

This block gathers sixteen interrupt sources on a board and presents them to a host processor as one active-high, level-sensitive request line. Each source that shows a low-to-high transition leaves a sticky pending flag. The host line is raised whenever a pending flag is also enabled. The sources are taken as already synchronous to the block clock.

Software works with a small 16-bit register window on a plain synchronous bus. The bus carries an address, a write strobe, write data and registered read data. The enable mask is changed only by writing ones to one of two addresses: one sets enable bits and the other clears them. Pending flags are acknowledged by writing ones to the status address. No read-modify-write sequence is ever needed.

A typical start-up sequence writes all ones to the mask-clear address and then all ones to the status address. After that, software enables the sources it serves, one at a time.

Top module: `board_irq_expander`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `host_irq` is 0 and `bus_rdata` is 0. The enable mask and all pending flags reset to 0, and the stored previous level of every source resets to 0.
- R2: A low-to-high change on `irq_src[i]` sets pending bit i. Reading offset 0x16 returns the pending flags, with bit i belonging to source i. A source that stays high does not set its flag again after the flag has been cleared.
- R3: A write to offset 0x16 clears each pending bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: If a rising edge of source i and a write-one-to-clear of pending bit i occur in the same cycle, pending bit i ends up set.
- R5: A write to offset 0x1A sets each enable bit whose write-data bit is 1. Bits written as 0 keep their value. Reading 0x1A returns the enable mask.
- R6: A write to offset 0x1C clears each enable bit whose write-data bit is 1. Bits written as 0 keep their value. Reading 0x1C also returns the enable mask.
- R7: Reading offset 0x18 returns the present levels of `irq_src`, with no mask applied. A write to 0x18 changes no state.
- R8: `host_irq` equals the OR over all bits of (pending AND enable), as those registers stood one clock earlier.
- R9: Writes to any offset other than 0x16, 0x1A and 0x1C change neither the mask nor the pending flags. Reads from any offset other than 0x16, 0x18, 0x1A and 0x1C return 0.
- R10: `bus_rdata` is registered. It shows the register selected by `bus_addr` one clock earlier, with the contents that register held at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_SRC (16) | Synchronous interrupt source levels |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wr_en | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | NUM_SRC (16) | Write data |
| bus_rdata | output | NUM_SRC (16) | Registered read data |
| host_irq | output | 1 | Level-high interrupt request to the host |

## Verification
The bench runs a behavioural model in parallel with the design and compares both outputs after every clock.

- Single-bit edges followed by a long high level show whether flags are edge-latched rather than level-followed.
- Partial write-one-to-clear patterns, such as 0x00F0 against a mixed pending set, show whether clearing is per bit rather than whole-word.
- A rising edge placed in the same cycle as its own clear tests the set-priority rule.
- All sixteen sources rising at once, combined with a sparse mask such as 0x8001, shows whether the host line depends on the mask rather than on the raw flags.
- Writes and reads at the raw-status offset and at unused offsets show that read-only and unmapped addresses leave state untouched.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    // Register offsets; software depends on these exact positions.
    localparam int unsigned OFF_PENDING = 'h16;
    localparam int unsigned OFF_LIVE    = 'h18;
    localparam int unsigned OFF_MSET    = 'h1A;
    localparam int unsigned OFF_MCLR    = 'h1C;

    typedef enum logic [2:0] {
        SEL_NONE    = 3'd0,
        SEL_PENDING = 3'd1,
        SEL_LIVE    = 3'd2,
        SEL_MSET    = 3'd3,
        SEL_MCLR    = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/irqx_decode.sv
module irqx_decode
    import irqx_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output reg_sel_e          sel,
    output logic              wr_pending,
    output logic              wr_mset,
    output logic              wr_mclr
);

    always_comb begin
        if (addr == ADDR_W'(OFF_PENDING)) begin
            sel = SEL_PENDING;
        end else if (addr == ADDR_W'(OFF_LIVE)) begin
            sel = SEL_LIVE;
        end else if (addr == ADDR_W'(OFF_MSET)) begin
            sel = SEL_MSET;
        end else if (addr == ADDR_W'(OFF_MCLR)) begin
            sel = SEL_MCLR;
        end else begin
            sel = SEL_NONE;
        end
        wr_pending = wr_en && (sel == SEL_PENDING);
        wr_mset    = wr_en && (sel == SEL_MSET);
        wr_mclr    = wr_en && (sel == SEL_MCLR);
    end

endmodule

// File: rtl/irqx_pending.sv
module irqx_pending #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic               clr_en,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] pending
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] prev;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] clr_mask;

    always_comb begin
        rise     = src & ~st_q.prev;
        clr_mask = clr_en ? clr_bits : '0;
        st_d      = st_q;
        st_d.prev = src;
        // A new edge overrides a clear in the same cycle.
        st_d.pend = (st_q.pend & ~clr_mask) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pend;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit_chk
        AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (src[i] && !st_q.prev[i]) |=> pending[i]); // R2
        AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pending[i]) |-> $past(src[i] && !st_q.prev[i])); // R2
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_bits[i] && !(src[i] && !st_q.prev[i])) |=> !pending[i]); // R3
        AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_bits[i] && src[i] && !st_q.prev[i]) |=> pending[i]); // R4
        AST_ZERO_BIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (pending[i] && !(clr_en && clr_bits[i])) |=> pending[i]); // R3
    end

endmodule

// File: rtl/irqx_mask.sv
module irqx_mask #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic               clr_en,
    input  logic [NUM_SRC-1:0] bits,
    output logic [NUM_SRC-1:0] mask
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
    } mask_state_t;

    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en) begin
            st_d.en = st_q.en | bits;
        end else if (clr_en) begin
            st_d.en = st_q.en & ~bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask = st_q.en;

    AST_MASK_SET_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((mask & $past(bits)) == $past(bits))); // R5
    AST_MASK_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> ((mask & ~$past(bits)) == ($past(mask) & ~$past(bits)))); // R5
    AST_MASK_CLR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((mask & $past(bits)) == '0)); // R6
    AST_MASK_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(mask)); // R9

endmodule

// File: rtl/board_irq_expander.sv
module board_irq_expander
    import irqx_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr_en,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               host_irq
);

    typedef struct packed {
        logic [NUM_SRC-1:0] rdata;
        logic               irq;
    } top_state_t;

    top_state_t         st_d, st_q;
    reg_sel_e           sel;
    logic               wr_pending;
    logic               wr_mset;
    logic               wr_mclr;
    logic [NUM_SRC-1:0] pending_w;
    logic [NUM_SRC-1:0] mask_w;

    irqx_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr       (bus_addr),
        .wr_en      (bus_wr_en),
        .sel        (sel),
        .wr_pending (wr_pending),
        .wr_mset    (wr_mset),
        .wr_mclr    (wr_mclr)
    );

    irqx_pending #(.NUM_SRC(NUM_SRC)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (irq_src),
        .clr_en   (wr_pending),
        .clr_bits (bus_wdata),
        .pending  (pending_w)
    );

    irqx_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_mset),
        .clr_en (wr_mclr),
        .bits   (bus_wdata),
        .mask   (mask_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(pending_w & mask_w);
        unique case (sel)
            SEL_PENDING: st_d.rdata = pending_w;
            SEL_LIVE:    st_d.rdata = irq_src;
            SEL_MSET,
            SEL_MCLR:    st_d.rdata = mask_w;
            default:     st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign host_irq  = st_q.irq;

    AST_IRQ_ONE_CLOCK_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == $past(|(pending_w & mask_w))); // R8
    AST_LIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_LIVE) |=> (bus_rdata == $past(irq_src))); // R7
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |=> (bus_rdata == '0)); // R9
    AST_MASK_READ_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_MSET || sel == SEL_MCLR) |=> (bus_rdata == $past(mask_w))); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!host_irq && bus_rdata == '0)); // R1

endmodule

// File: tb/board_irq_expander_bench.sv
`timescale 1ns/1ps
module board_irq_expander_bench;

    localparam int A_PEND = 'h16;
    localparam int A_LIVE = 'h18;
    localparam int A_MSET = 'h1A;
    localparam int A_MCLR = 'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_src = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        host_irq;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    // reference model state
    int unsigned m_pend = 0, m_mask = 0, m_prev = 0, m_rd = 0;
    bit m_irq = 1'b0;

    always #2.5 clk = ~clk;

    board_irq_expander u_board_irq_expander (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .host_irq(host_irq)
    );

    task automatic check(input string tag);
        compared++;
        if (host_irq !== m_irq) begin
            mismatched++;
            $display("FAIL %s host_irq actual=%0b expected=%0b at %0t", tag, host_irq, m_irq, $time);
        end
        compared++;
        if (bus_rdata !== 16'(m_rd)) begin
            mismatched++;
            $display("FAIL %s bus_rdata actual=%04h expected=%04h at %0t", tag, bus_rdata, m_rd, $time);
        end
    endtask

    // one clock: model advances with the pre-edge inputs, then compare
    task automatic cyc(input string tag);
        int unsigned src, rd, rise, clr, a;
        bit irqn;
        src = irq_src;
        a = bus_addr;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_pend = 0; m_mask = 0; m_prev = 0; m_rd = 0; m_irq = 0;
        end else begin
            if (a == A_PEND) rd = m_pend;
            else if (a == A_LIVE) rd = src;
            else if (a == A_MSET || a == A_MCLR) rd = m_mask;
            else rd = 0;
            irqn = (m_pend & m_mask) != 0;
            rise = src & ~m_prev & 32'hFFFF;
            clr = (bus_wr_en && a == A_PEND) ? bus_wdata : 0;
            m_pend = ((m_pend & ~clr) | rise) & 32'hFFFF;
            if (bus_wr_en && a == A_MSET) m_mask = (m_mask | bus_wdata) & 32'hFFFF;
            if (bus_wr_en && a == A_MCLR) m_mask = m_mask & ~32'(bus_wdata);
            m_prev = src;
            m_rd = rd;
            m_irq = irqn;
        end
        check(tag);
    endtask

    task automatic wr(input int a, input logic [15:0] d, input string tag);
        bus_addr = 8'(a); bus_wdata = d; bus_wr_en = 1'b1;
        cyc(tag);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, input string tag);
        bus_addr = 8'(a);
        cyc(tag);
        bus_addr = 8'h00;
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(tag);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3, "R1");
        rst_n = 1'b1;
        idle(1, "R1");
        // start-up sequence: disable all, clear all
        wr(A_MCLR, 16'hFFFF, "R6");
        wr(A_PEND, 16'hFFFF, "R3");
        rd(A_MSET, "R6");
        // R2: single edge, then held high
        irq_src = 16'h0008;
        idle(1, "R2");
        rd(A_PEND, "R2");
        idle(1, "R2");
        // R3 with R2: clear while source stays high, no re-latch
        wr(A_PEND, 16'h0008, "R3");
        rd(A_PEND, "R2");
        idle(1, "R2");
        irq_src = 16'h0000;
        idle(1, "R2");
        irq_src = 16'h0008;
        idle(1, "R2");
        // R5 + R8: enable source 3, host line follows one clock later
        wr(A_MSET, 16'h0008, "R5");
        idle(3, "R8");
        rd(A_MSET, "R5");
        rd(A_MCLR, "R6");
        // R3: partial clear of a mixed pending set
        irq_src = 16'h0000;
        idle(1, "R3");
        irq_src = 16'h3CF0;
        idle(1, "R3");
        wr(A_PEND, 16'h00F0, "R3");
        rd(A_PEND, "R3");
        idle(1, "R3");
        // R4: edge and clear on the same bit in the same cycle
        irq_src = 16'h0000;
        idle(1, "R4");
        irq_src = 16'h0100;
        wr(A_PEND, 16'h0100, "R4");
        rd(A_PEND, "R4");
        idle(1, "R4");
        // R7: live levels and write to read-only offset
        irq_src = 16'hA5C3;
        rd(A_LIVE, "R7");
        wr(A_LIVE, 16'hFFFF, "R7");
        rd(A_PEND, "R7");
        rd(A_MSET, "R7");
        irq_src = 16'h5A3C;
        rd(A_LIVE, "R7");
        // R9: unmapped offsets
        wr(8'h20, 16'hFFFF, "R9");
        wr(8'h17, 16'hFFFF, "R9");
        rd(8'h20, "R9");
        rd(8'h00, "R9");
        rd(A_PEND, "R9");
        rd(A_MCLR, "R9");
        // R6 + R8: disable, line drops one clock later
        wr(A_MCLR, 16'hFFFF, "R6");
        idle(2, "R8");
        wr(A_PEND, 16'hFFFF, "R3");
        // R8: all sources rise together, sparse mask
        irq_src = 16'h0000;
        idle(1, "R8");
        wr(A_MSET, 16'h8001, "R5");
        irq_src = 16'hFFFF;
        idle(2, "R8");
        wr(A_PEND, 16'h8000, "R8");
        idle(2, "R8");
        wr(A_PEND, 16'h0001, "R8");
        idle(2, "R8");
        wr(A_MSET, 16'h0002, "R8");
        idle(2, "R8");
        // R10: alternating addresses, one clock latency
        for (int k = 0; k < 6; k++) begin
            bus_addr = (k % 2 == 0) ? 8'(A_PEND) : 8'(A_MSET);
            cyc("R10");
        end
        bus_addr = 8'h00;
        // R1: reset again mid-operation
        rst_n = 1'b0;
        idle(2, "R1");
        rst_n = 1'b1;
        irq_src = 16'h0000;
        idle(1, "R1");
        rd(A_MSET, "R1");
        rd(A_PEND, "R1");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule